// File: doc/BRIEF.md
# Busy-interrupt ADC read controller

This block is the host-side master for a successive-approximation converter run in its four-wire chip-select mode with a busy indicator. A single start request makes it raise the convert line while the serial data-in line is high, which puts the converter into chip-select mode. It then drops the data-in line and keeps it low for the whole conversion. The controller has no fixed conversion delay. It waits for the converter's data-out line to fall from its pulled-up idle level, and takes that edge as the conversion-done interrupt.

After the interrupt the controller drives a serial clock that idles low and makes nineteen pulses. It collects the eighteen result bits MSB first. By default it samples each bit on the falling edge that also shifts out the next bit. A parameter moves sampling to the rising edges instead. One SCK period after the nineteenth falling edge, it raises the data-in line, drops the convert line and presents the word with a one-cycle valid strobe. If the interrupt does not come within a bounded number of clocks, the controller gives up and raises a one-cycle timeout pulse instead.

Top module: `busy_adc_reader`

## Requirements
- R1: In reset and while idle: cnv_o is low, sdi_o is high, sck_o is low, and busy_o, valid_o and timeout_o are low.
- R2: A start_i pulse while idle makes cnv_o rise on the next clock with sdi_o high. sdi_o stays high for exactly SEL_CLKS clocks after that rise and then goes low.
- R3: While cnv_o is high and the transfer has not ended, sdi_o stays low after the select window, and cnv_o stays high until the readback has finished.
- R4: The conversion-done event is a falling edge of sdo_i, seen after SYNC_STAGES synchronizing flops. No SCK pulse is produced before that edge.
- R5: The readback produces exactly DATA_BITS+1 SCK pulses. Each high phase lasts SCK_HALF_CLKS clocks, and sck_o is low outside the readback.
- R6: The converter places bit DATA_BITS-k (MSB = bit DATA_BITS-1) on sdo_i after SCK falling edge k. With CAPTURE_RISE=0 the controller samples on falling edges 2 to DATA_BITS+1. With CAPTURE_RISE=1 it samples on rising edges 2 to DATA_BITS+1. data_o equals the converter's word in either mode.
- R7: cnv_o falls exactly 2*SCK_HALF_CLKS clocks after the last SCK falling edge. In that same cycle sdi_o rises, busy_o drops and valid_o pulses high for one cycle with data_o.
- R8: If no sdo_i falling edge arrives within TIMEOUT_CLKS clocks of the end of the select window, timeout_o pulses for one cycle, cnv_o falls and sdi_o rises. cnv_o has then been high for SEL_CLKS+TIMEOUT_CLKS clocks, and valid_o does not pulse.
- R9: A start_i pulse while busy_o is high is ignored: the transfer produces exactly one valid_o pulse and its data is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Request one conversion and readback |
| busy_o | output | 1 | High from accepted start until done or timeout |
| cnv_o | output | 1 | Convert line to the converter |
| sdi_o | output | 1 | Serial data-in line, used for mode select and termination |
| sck_o | output | 1 | Serial clock, idle low |
| sdo_i | input | 1 | Converter data-out, pulled high when released |
| data_o | output | DATA_BITS | Captured result word |
| valid_o | output | 1 | One-cycle strobe marking data_o |
| timeout_o | output | 1 | One-cycle pulse when the ready edge never arrives |

## Verification
The bench builds two copies of the controller side by side. The first uses falling-edge capture with SCK_HALF_CLKS=4, SEL_CLKS=3 and TIMEOUT_CLKS=200. The second uses rising-edge capture with SCK_HALF_CLKS=5, SEL_CLKS=2 and TIMEOUT_CLKS=300. With these settings both capture options run under the same random conversion delays. The short timeouts put the give-up path within reach of a short run, and the measured select width, high-phase length and tail gap can be told apart from their neighbouring values.

// File: rtl/busy_adc_reader_pkg.sv
package busy_adc_reader_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SELECT,
        ST_WAIT,
        ST_SHIFT,
        ST_TAIL
    } rd_state_e;

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/busy_adc_sync.sv
module busy_adc_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o,
    output logic fell_o
);

    typedef struct packed {
        logic [STAGES-1:0] sh;
        logic              prev;
    } sync_t;

    sync_t q, d;

    always_comb begin
        d = q;
        d.sh = {q.sh[STAGES-2:0], d_i};
        d.prev = q.sh[STAGES-1];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '1;
        else        q <= d;
    end

    assign q_o    = q.sh[STAGES-1];
    assign fell_o = q.prev & ~q.sh[STAGES-1];

endmodule

// File: rtl/busy_adc_sckgen.sv
module busy_adc_sckgen #(
    parameter int HALF_CLKS = 4,
    parameter int PULSES    = 19
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         run_i,
    output logic                         sck_o,
    output logic                         rise_o,
    output logic                         fall_o,
    output logic [$clog2(PULSES+1)-1:0]  count_o
);

    localparam int HW = $clog2(HALF_CLKS + 1);
    localparam int PW = $clog2(PULSES + 1);

    typedef struct packed {
        logic          sck;
        logic [HW-1:0] hc;
        logic [PW-1:0] np;
    } gen_t;

    gen_t q, d;
    logic tick;

    always_comb begin
        d    = q;
        tick = run_i && (q.hc == HW'(HALF_CLKS - 1));
        if (!run_i) begin
            d = '0;
        end else if (tick) begin
            d.hc  = '0;
            d.sck = ~q.sck;
            if (!q.sck) d.np = q.np + 1'b1;
        end else begin
            d.hc = q.hc + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign sck_o   = q.sck;
    assign rise_o  = tick & ~q.sck;
    assign fall_o  = tick & q.sck;
    assign count_o = q.np;

    a_r5_sck_low_when_stopped: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> !sck_o);
    a_r5_fall_after_rise: assert property (@(posedge clk) disable iff (!rst_n)
        fall_o |-> (count_o != '0));
    a_r5_pulse_bound: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |-> (count_o < PW'(PULSES)));

endmodule

// File: rtl/busy_adc_reader.sv
module busy_adc_reader
    import busy_adc_reader_pkg::*;
#(
    parameter int DATA_BITS     = 18,
    parameter int SCK_HALF_CLKS = 4,
    parameter int SEL_CLKS      = 3,
    parameter int TIMEOUT_CLKS  = 4096,
    parameter int SYNC_STAGES   = 2,
    parameter bit CAPTURE_RISE  = 1'b0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start_i,
    output logic                 busy_o,
    output logic                 cnv_o,
    output logic                 sdi_o,
    output logic                 sck_o,
    input  logic                 sdo_i,
    output logic [DATA_BITS-1:0] data_o,
    output logic                 valid_o,
    output logic                 timeout_o
);

    localparam int PULSES    = DATA_BITS + 1;
    localparam int PW        = $clog2(PULSES + 1);
    localparam int TAIL_CLKS = 2 * SCK_HALF_CLKS;
    localparam int CMAX      = max3(SEL_CLKS, TIMEOUT_CLKS, TAIL_CLKS);
    localparam int CW        = $clog2(CMAX + 1);

    typedef struct packed {
        rd_state_e            st;
        logic                 cnv;
        logic                 sdi;
        logic                 valid;
        logic                 err;
        logic [CW-1:0]        cnt;
        logic [DATA_BITS-1:0] shreg;
        logic [DATA_BITS-1:0] data;
    } ctl_t;

    ctl_t q, d;

    logic          sdo_s, sdo_fell;
    logic          run, sck_rise, sck_fall, cap_evt;
    logic [PW-1:0] sck_cnt;

    busy_adc_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .d_i    (sdo_i),
        .q_o    (sdo_s),
        .fell_o (sdo_fell)
    );

    busy_adc_sckgen #(.HALF_CLKS(SCK_HALF_CLKS), .PULSES(PULSES)) u_sck (
        .clk     (clk),
        .rst_n   (rst_n),
        .run_i   (run),
        .sck_o   (sck_o),
        .rise_o  (sck_rise),
        .fall_o  (sck_fall),
        .count_o (sck_cnt)
    );

    // sampling edge variant: index 1 edges carry no data
    generate
        if (CAPTURE_RISE) begin : g_cap_rise
            assign cap_evt = sck_rise && (sck_cnt >= PW'(1));
        end else begin : g_cap_fall
            assign cap_evt = sck_fall && (sck_cnt >= PW'(2));
        end
    endgenerate

    assign run = (q.st == ST_SHIFT);

    always_comb begin
        d       = q;
        d.valid = 1'b0;
        d.err   = 1'b0;
        unique case (q.st)
            ST_IDLE: begin
                d.cnt = '0;
                if (start_i) begin
                    d.st  = ST_SELECT;
                    d.cnv = 1'b1;
                    d.sdi = 1'b1;
                end
            end
            ST_SELECT: begin
                d.cnt = q.cnt + 1'b1;
                if (q.cnt == CW'(SEL_CLKS - 1)) begin
                    d.sdi = 1'b0;
                    d.cnt = '0;
                    d.st  = ST_WAIT;
                end
            end
            ST_WAIT: begin
                d.cnt = q.cnt + 1'b1;
                if (sdo_fell) begin
                    d.cnt = '0;
                    d.st  = ST_SHIFT;
                end else if (q.cnt == CW'(TIMEOUT_CLKS - 1)) begin
                    d.err = 1'b1;
                    d.cnv = 1'b0;
                    d.sdi = 1'b1;
                    d.st  = ST_IDLE;
                end
            end
            ST_SHIFT: begin
                if (cap_evt) d.shreg = {q.shreg[DATA_BITS-2:0], sdo_s};
                if (sck_fall && (sck_cnt == PW'(PULSES))) begin
                    d.cnt = '0;
                    d.st  = ST_TAIL;
                end
            end
            ST_TAIL: begin
                d.cnt = q.cnt + 1'b1;
                if (q.cnt == CW'(TAIL_CLKS - 1)) begin
                    d.cnv   = 1'b0;
                    d.sdi   = 1'b1;
                    d.valid = 1'b1;
                    d.data  = q.shreg;
                    d.st    = ST_IDLE;
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q     <= '0;
            q.st  <= ST_IDLE;
            q.sdi <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign busy_o    = (q.st != ST_IDLE);
    assign cnv_o     = q.cnv;
    assign sdi_o     = q.sdi;
    assign data_o    = q.data;
    assign valid_o   = q.valid;
    assign timeout_o = q.err;

    a_r1_idle_lines: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (!cnv_o && sdi_o && !sck_o));
    a_r2_sdi_high_at_cnv_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cnv_o) |-> sdi_o);
    a_r3_cnv_high_during_sck: assert property (@(posedge clk) disable iff (!rst_n)
        sck_o |-> (cnv_o && !sdi_o));
    a_r4_no_sck_before_ready: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sck_o) |-> busy_o);
    a_r7_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o);
    a_r7_valid_ends_cnv: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> (!cnv_o && sdi_o && $past(cnv_o)));
    a_r8_timeout_no_valid: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_o |-> (!valid_o && !cnv_o && sdi_o));
    a_r9_busy_holds_on_start: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i && cnv_o && !sck_o && !valid_o) |=> (busy_o || valid_o || timeout_o));

endmodule

// File: tb/busy_adc_reader_tb.sv
module busy_adc_model #(
    parameter int N        = 18,
    parameter int MIN_CONV = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cnv,
    input  logic         sdi,
    input  logic         sck,
    input  logic [N-1:0] word,
    input  int           dly,
    input  logic         hang,
    output logic         sdo,
    output int           viol,
    output int           sel_w,
    output int           hi_w,
    output int           tail_gap,
    output int           cnv_w,
    output int           pulses
);
    logic cnv_p, sdi_p, sck_p, drv, val, conv, rd;
    int cyc, t_rise, t_fall, t_hi, ccnt, fn;
    logic [N-1:0] w;

    always @(posedge clk) begin
        if (!rst_n) begin
            cnv_p <= 0; sdi_p <= 1; sck_p <= 0; drv <= 0; val <= 0; conv <= 0; rd <= 0;
            cyc <= 0; t_rise <= 0; t_fall <= 0; t_hi <= 0; ccnt <= 0; fn <= 0; w <= '0;
            viol <= 0; sel_w <= 0; hi_w <= 0; tail_gap <= 0; cnv_w <= 0; pulses <= 0;
        end else begin
            cyc <= cyc + 1; cnv_p <= cnv; sdi_p <= sdi; sck_p <= sck;
            if (cnv && !cnv_p) begin
                if (!sdi) viol <= viol + 1;
                conv <= 1; ccnt <= 1; w <= word; t_rise <= cyc; pulses <= 0;
            end else if (conv) begin
                ccnt <= ccnt + 1;
                if (cnv && ccnt >= MIN_CONV && sdi) viol <= viol + 1;
                if (!hang && ccnt >= dly) begin
                    conv <= 0; rd <= 1; drv <= 1; val <= 0; fn <= 0;
                end
            end
            if (!sdi && sdi_p && cnv) sel_w <= cyc - t_rise;
            if (sck && !sck_p) begin
                pulses <= pulses + 1; t_hi <= cyc;
                if (!rd) viol <= viol + 1;
            end
            if (!sck && sck_p && rd) begin
                fn <= fn + 1; t_fall <= cyc; hi_w <= cyc - t_hi;
                if (fn + 1 <= N) val <= w[N-1-fn];
                else drv <= 0;
            end
            if (sdi && !sdi_p && rd) drv <= 0;
            if (!cnv && cnv_p) begin
                tail_gap <= cyc - t_fall;
                cnv_w <= cyc - t_rise;
                if (conv && !hang) viol <= viol + 1;
                if (rd && fn < N) viol <= viol + 1;
                conv <= 0; rd <= 0; drv <= 0;
            end
        end
    end

    assign sdo = drv ? val : 1'b1;
endmodule

module busy_adc_reader_tb;
    localparam int NB = 18;
    localparam int HA = 4, SA = 3, TA = 200;
    localparam int HB = 5, SB = 2, TB = 300;

    logic clk = 0;
    logic rst_n = 0;
    logic start = 0;
    logic [NB-1:0] word = '0;
    int dly = 20;
    logic hang = 0;

    always #2 clk = ~clk;

    logic busy_a, cnv_a, sdi_a, sck_a, sdo_a, val_a, err_a;
    logic busy_b, cnv_b, sdi_b, sck_b, sdo_b, val_b, err_b;
    logic [NB-1:0] dat_a, dat_b;
    int viol_a, selw_a, hiw_a, gap_a, cnvw_a, pul_a;
    int viol_b, selw_b, hiw_b, gap_b, cnvw_b, pul_b;

    busy_adc_reader #(.DATA_BITS(NB), .SCK_HALF_CLKS(HA), .SEL_CLKS(SA),
                      .TIMEOUT_CLKS(TA), .SYNC_STAGES(2), .CAPTURE_RISE(1'b0)) u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start), .busy_o(busy_a), .cnv_o(cnv_a),
        .sdi_o(sdi_a), .sck_o(sck_a), .sdo_i(sdo_a), .data_o(dat_a), .valid_o(val_a),
        .timeout_o(err_a));

    busy_adc_reader #(.DATA_BITS(NB), .SCK_HALF_CLKS(HB), .SEL_CLKS(SB),
                      .TIMEOUT_CLKS(TB), .SYNC_STAGES(2), .CAPTURE_RISE(1'b1)) u_dut_r (
        .clk(clk), .rst_n(rst_n), .start_i(start), .busy_o(busy_b), .cnv_o(cnv_b),
        .sdi_o(sdi_b), .sck_o(sck_b), .sdo_i(sdo_b), .data_o(dat_b), .valid_o(val_b),
        .timeout_o(err_b));

    busy_adc_model #(.N(NB)) u_adc_a (
        .clk(clk), .rst_n(rst_n), .cnv(cnv_a), .sdi(sdi_a), .sck(sck_a), .word(word),
        .dly(dly), .hang(hang), .sdo(sdo_a), .viol(viol_a), .sel_w(selw_a), .hi_w(hiw_a),
        .tail_gap(gap_a), .cnv_w(cnvw_a), .pulses(pul_a));

    busy_adc_model #(.N(NB)) u_adc_b (
        .clk(clk), .rst_n(rst_n), .cnv(cnv_b), .sdi(sdi_b), .sck(sck_b), .word(word),
        .dly(dly), .hang(hang), .sdo(sdo_b), .viol(viol_b), .sel_w(selw_b), .hi_w(hiw_b),
        .tail_gap(gap_b), .cnv_w(cnvw_b), .pulses(pul_b));

    int vectors = 0, fails = 0;
    int nva = 0, nvb = 0, nea = 0, neb = 0;
    logic [NB-1:0] cap_a, cap_b;
    bit finished = 0;

    always @(posedge clk) begin
        if (val_a) begin nva = nva + 1; cap_a = dat_a; end
        if (val_b) begin nvb = nvb + 1; cap_b = dat_b; end
        if (err_a) nea = nea + 1;
        if (err_b) neb = neb + 1;
    end

    task automatic chk(input string tag, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    endtask

    function automatic logic [NB-1:0] rand_word();
        return NB'($urandom);
    endfunction

    task automatic xfer(input logic [NB-1:0] w, input int d, input logic h, input bit extra);
        @(negedge clk);
        word = w; dly = d; hang = h;
        nva = 0; nvb = 0; nea = 0; neb = 0;
        start = 1;
        @(negedge clk);
        start = 0;
        chk("R2 cnv rises after start (a)", int'(cnv_a && sdi_a), 1);
        chk("R2 cnv rises after start (b)", int'(cnv_b && sdi_b), 1);
        for (int i = 0; i < 4000; i++) begin
            if (extra && i == 40) begin
                start = 1;
                @(negedge clk);
                start = 0;
            end else begin
                @(negedge clk);
            end
            if (!busy_a && !busy_b) break;
        end
        repeat (2) @(negedge clk);
        chk("R1 cnv low after end (a)", int'(cnv_a), 0);
        chk("R1 sdi high after end (b)", int'(sdi_b), 1);
        chk("R3/R4 protocol violations (a)", viol_a, 0);
        chk("R3/R4 protocol violations (b)", viol_b, 0);
        if (!h) begin
            chk("R2 select width (a)", selw_a, SA);
            chk("R2 select width (b)", selw_b, SB);
            chk("R7 one valid (a)", nva, 1);
            chk("R9 one valid despite extra start (b)", nvb, 1);
            chk("R6 falling-capture word", int'(cap_a), int'(w));
            chk("R6 rising-capture word", int'(cap_b), int'(w));
            chk("R5 pulse count (a)", pul_a, NB + 1);
            chk("R5 pulse count (b)", pul_b, NB + 1);
            chk("R5 high phase (a)", hiw_a, HA);
            chk("R5 high phase (b)", hiw_b, HB);
            chk("R7 tail gap (a)", gap_a, 2 * HA);
            chk("R7 tail gap (b)", gap_b, 2 * HB);
            chk("R8 no timeout (a)", nea, 0);
            chk("R8 no timeout (b)", neb, 0);
        end else begin
            chk("R8 timeout pulse (a)", nea, 1);
            chk("R8 timeout pulse (b)", neb, 1);
            chk("R8 no valid on timeout (a)", nva, 0);
            chk("R8 no valid on timeout (b)", nvb, 0);
            chk("R8 cnv high time (a)", cnvw_a, SA + TA);
            chk("R8 cnv high time (b)", cnvw_b, SB + TB);
            chk("R4 no sck without ready (a)", pul_a, 0);
        end
    endtask

    initial begin
        void'($urandom(32'd4242));
        repeat (5) @(negedge clk);
        chk("R1 reset cnv (a)", int'(cnv_a), 0);
        chk("R1 reset sdi (a)", int'(sdi_a), 1);
        chk("R1 reset sck (b)", int'(sck_b), 0);
        chk("R1 reset busy", int'(busy_a | busy_b), 0);
        chk("R1 reset strobes", int'(val_a | val_b | err_a | err_b), 0);
        rst_n = 1;
        repeat (3) @(negedge clk);
        xfer(18'h3FFFF, 10, 1'b0, 1'b0);
        xfer(18'h00000, 150, 1'b0, 1'b0);
        xfer(18'h20001, 12, 1'b0, 1'b0);
        xfer(18'h15555, 60, 1'b0, 1'b0);
        xfer(18'h2AAAA, 33, 1'b0, 1'b1);
        for (int k = 0; k < 24; k++) begin
            xfer(rand_word(), 10 + int'($urandom % 140), 1'b0, (k % 5) == 2);
        end
        xfer(18'h12345, 20, 1'b1, 1'b0);
        xfer(18'h0F0F0, 25, 1'b0, 1'b0);
        finish_run();
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end
endmodule